// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the purely combinational hazard logic of a five-stage, in-order, 32-bit pipeline in which branch and jump-register operands are compared during decode. For each of the two source operands of the instruction in decode it takes the register number and two flags. One flag says whether the ALU needs the operand. The other says whether the decode-stage branch comparison needs it. It compares these against the destinations of the instructions in the execute and memory stages. From that it decides whether the front end must stall, whether the stall is caused by a branch operand, and which value each operand should use.

The unit has two modes, chosen by a select pin. In stall-only mode every dependency on an older in-flight instruction is resolved by stalling. In forwarding mode the unit avoids a stall wherever the value already exists. The execute-stage ALU result and the memory-stage final write value are routed to the ALU operands. The memory-stage write value is also routed into the decode branch comparison. Loads in execute, and any producer in execute for a branch operand, still stall.

There is no writeback input. The register file is expected to pass a value written in a cycle straight through to a read in decode in that same cycle. The stall output drives the hold of the program counter and of the fetch/decode register, and the insertion of a bubble into execute. These are control pins, not a data stream, so they carry no handshake.

Top module: `hazard_fwd_unit`

## Requirements
- R1: A stage takes part in hazard detection only when its write enable is 1 and its destination number is not 0. With destination 0 or write enable 0 it never causes a stall, a forward select or a branch forward flag, even if a source number equals it.
- R2: In forwarding mode, an ALU-needed operand that matches a qualified memory-stage destination gets select 2'b10 and the value `mem_wr_val`. This holds whether or not that instruction is a load. The rs and rt operands are judged independently.
- R3: In forwarding mode, an ALU-needed operand that matches a qualified execute-stage destination whose instruction is not a load gets select 2'b01 and the value `ex_alu_val`.
- R4: In forwarding mode, an ALU-needed operand that matches a qualified execute-stage load raises `stall` while `branch_stall` stays 0.
- R5: When an operand matches both qualified stages, the execute-stage result (select 2'b01) wins over the memory-stage value.
- R6: In stall-only mode (`fwd_mode`=0), any ALU-needed operand matching a qualified execute or memory destination raises `stall`. No select or branch forward flag is ever nonzero in this mode.
- R7: A branch-needed operand matching a qualified execute-stage destination raises both `stall` and `branch_stall` in either mode.
- R8: A branch-needed operand matching a qualified memory-stage destination, with no execute-stage match, behaves in one of two ways. In forwarding mode with a non-load instruction it sets that operand's branch forward flag and its branch value becomes `mem_wr_val`, without a stall. In stall-only mode, or when the instruction is a load, it raises `stall` with `branch_stall` 0.
- R9: An operand whose ALU flag and branch flag are both 0 causes no hazard, whatever its number.
- R10: While `stall` is 1, `hold_front` and `insert_bubble` are 1, both selects are 2'b00, both branch forward flags are 0, and all operand values equal the register file values. While `stall` is 0, `hold_front` and `insert_bubble` are 0.
- R11: `hz_status` reads 2'b10 when stalling, 2'b01 when any select or branch forward flag is active without a stall, and 2'b00 otherwise. With a select of 2'b00 an ALU value equals the register file value, and with a branch flag of 0 a branch value equals the register file value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwd_mode | input | 1 | 1 = stall plus forwarding, 0 = stall only |
| dec_rs_num | input | 5 | rs register number of the decode instruction |
| dec_rt_num | input | 5 | rt register number of the decode instruction |
| dec_rs_alu | input | 1 | ALU needs rs |
| dec_rt_alu | input | 1 | ALU needs rt |
| dec_rs_br | input | 1 | Branch/jump-register comparison needs rs |
| dec_rt_br | input | 1 | Branch comparison needs rt |
| dec_rs_val | input | 32 | Register file value read for rs |
| dec_rt_val | input | 32 | Register file value read for rt |
| ex_dest | input | 5 | Destination number of the execute-stage instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_alu_val | input | 32 | Execute-stage ALU result |
| mem_dest | input | 5 | Destination number of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_wr_val | input | 32 | Final value the memory-stage instruction will write |
| stall | output | 1 | Stall the front end |
| branch_stall | output | 1 | Stall caused by a branch operand produced in execute |
| hold_front | output | 1 | Hold PC and fetch/decode register |
| insert_bubble | output | 1 | Replace the execute entry by a bubble |
| fwd_sel_rs | output | 2 | rs ALU select: 00 none, 01 execute ALU result, 10 memory write value |
| fwd_sel_rt | output | 2 | rt ALU select, same encoding |
| alu_rs_val | output | 32 | rs value for the ALU |
| alu_rt_val | output | 32 | rt value for the ALU |
| br_fwd_rs | output | 1 | rs branch value forwarded from memory stage |
| br_fwd_rt | output | 1 | rt branch value forwarded from memory stage |
| br_rs_val | output | 32 | rs value for the branch comparison |
| br_rt_val | output | 32 | rt value for the branch comparison |
| hz_status | output | 2 | 00 none, 01 forwarding, 10 stall |

## Verification
No register lies between any input and any output, so every result is due in the same cycle as the stimulus that causes it, after zero clock edges. The bench changes inputs on the falling clock edge and samples all outputs 5 ns later, before the next rising edge. Each vector is therefore judged on settled values of its own inputs alone. Operand values are checked against fixed, distinct register file, ALU and memory values, so a wrong mux leg shows up as a wrong pattern rather than as a coincidence.

// File: rtl/hzu_pkg.sv
package hzu_pkg;
  typedef enum logic [1:0] {
    FWD_NONE = 2'b00,
    FWD_EXM  = 2'b01,
    FWD_WB   = 2'b10
  } fwd_sel_e;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'b00,
    HS_FWD   = 2'b01,
    HS_STALL = 2'b10
  } hz_status_e;
endpackage

// File: rtl/hzu_match.sv
module hzu_match #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic [AW-1:0]           dest,
  input  logic                    wen,
  input  logic [NSRC-1:0][AW-1:0] src,
  input  logic [NSRC-1:0]         need,
  output logic [NSRC-1:0]         hit
);
  logic live;
  // register 0 never carries a result worth waiting for
  assign live = wen && (dest != '0);

  for (genvar i = 0; i < NSRC; i++) begin : g_cmp
    assign hit[i] = live && need[i] && (src[i] == dest);
  end
endmodule

// File: rtl/hzu_alu_path.sv
module hzu_alu_path
  import hzu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            fwd_mode,
  input  logic            ex_hit,
  input  logic            mem_hit,
  input  logic            ex_load,
  input  logic            kill,
  input  logic [XLEN-1:0] rf_val,
  input  logic [XLEN-1:0] ex_val,
  input  logic [XLEN-1:0] mem_val,
  output logic            stall_req,
  output fwd_sel_e        sel,
  output logic [XLEN-1:0] val
);
  fwd_sel_e raw_sel;

  always_comb begin
    if (fwd_mode) stall_req = ex_hit && ex_load;
    else          stall_req = ex_hit || mem_hit;
  end

  always_comb begin
    raw_sel = FWD_NONE;
    if (fwd_mode) begin
      if (ex_hit) begin
        if (!ex_load) raw_sel = FWD_EXM;
      end else if (mem_hit) begin
        raw_sel = FWD_WB;
      end
    end
  end

  assign sel = kill ? FWD_NONE : raw_sel;

  always_comb begin
    case (sel)
      FWD_EXM: val = ex_val;
      FWD_WB:  val = mem_val;
      default: val = rf_val;
    endcase
  end
endmodule

// File: rtl/hzu_branch_path.sv
module hzu_branch_path #(
  parameter int XLEN = 32
) (
  input  logic            fwd_mode,
  input  logic            ex_hit,
  input  logic            mem_hit,
  input  logic            mem_load,
  input  logic            kill,
  input  logic [XLEN-1:0] rf_val,
  input  logic [XLEN-1:0] mem_val,
  output logic            stall_req,
  output logic            bstall_req,
  output logic            fwd,
  output logic [XLEN-1:0] val
);
  logic mem_can_fwd;
  logic raw_fwd;

  assign mem_can_fwd = fwd_mode && !mem_load;
  assign bstall_req  = ex_hit;
  assign stall_req   = ex_hit || (mem_hit && !mem_can_fwd);
  assign raw_fwd     = !ex_hit && mem_hit && mem_can_fwd;
  assign fwd         = raw_fwd && !kill;
  assign val         = fwd ? mem_val : rf_val;
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hzu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic            fwd_mode,
  input  logic [AW-1:0]   dec_rs_num,
  input  logic [AW-1:0]   dec_rt_num,
  input  logic            dec_rs_alu,
  input  logic            dec_rt_alu,
  input  logic            dec_rs_br,
  input  logic            dec_rt_br,
  input  logic [XLEN-1:0] dec_rs_val,
  input  logic [XLEN-1:0] dec_rt_val,
  input  logic [AW-1:0]   ex_dest,
  input  logic            ex_wen,
  input  logic            ex_load,
  input  logic [XLEN-1:0] ex_alu_val,
  input  logic [AW-1:0]   mem_dest,
  input  logic            mem_wen,
  input  logic            mem_load,
  input  logic [XLEN-1:0] mem_wr_val,
  output logic            stall,
  output logic            branch_stall,
  output logic            hold_front,
  output logic            insert_bubble,
  output logic [1:0]      fwd_sel_rs,
  output logic [1:0]      fwd_sel_rt,
  output logic [XLEN-1:0] alu_rs_val,
  output logic [XLEN-1:0] alu_rt_val,
  output logic            br_fwd_rs,
  output logic            br_fwd_rt,
  output logic [XLEN-1:0] br_rs_val,
  output logic [XLEN-1:0] br_rt_val,
  output logic [1:0]      hz_status
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][AW-1:0]   src;
  logic [NSRC-1:0][XLEN-1:0] rf;
  logic [NSRC-1:0]           need_alu, need_br;
  logic [NSRC-1:0]           ex_alu_hit, mem_alu_hit, ex_br_hit, mem_br_hit;
  logic [NSRC-1:0]           alu_stall, br_stall, br_bstall, br_fwd;
  fwd_sel_e                  sel [NSRC];
  logic [NSRC-1:0][XLEN-1:0] alu_val, br_val;
  hz_status_e                status;

  assign src      = {dec_rt_num, dec_rs_num};
  assign rf       = {dec_rt_val, dec_rs_val};
  assign need_alu = {dec_rt_alu, dec_rs_alu};
  assign need_br  = {dec_rt_br, dec_rs_br};

  hzu_match #(.AW(AW), .NSRC(NSRC)) u_ex_alu (
    .dest(ex_dest), .wen(ex_wen), .src(src), .need(need_alu), .hit(ex_alu_hit));
  hzu_match #(.AW(AW), .NSRC(NSRC)) u_mem_alu (
    .dest(mem_dest), .wen(mem_wen), .src(src), .need(need_alu), .hit(mem_alu_hit));
  hzu_match #(.AW(AW), .NSRC(NSRC)) u_ex_br (
    .dest(ex_dest), .wen(ex_wen), .src(src), .need(need_br), .hit(ex_br_hit));
  hzu_match #(.AW(AW), .NSRC(NSRC)) u_mem_br (
    .dest(mem_dest), .wen(mem_wen), .src(src), .need(need_br), .hit(mem_br_hit));

  for (genvar i = 0; i < NSRC; i++) begin : g_op
    hzu_alu_path #(.XLEN(XLEN)) u_alu (
      .fwd_mode (fwd_mode),
      .ex_hit   (ex_alu_hit[i]),
      .mem_hit  (mem_alu_hit[i]),
      .ex_load  (ex_load),
      .kill     (stall),
      .rf_val   (rf[i]),
      .ex_val   (ex_alu_val),
      .mem_val  (mem_wr_val),
      .stall_req(alu_stall[i]),
      .sel      (sel[i]),
      .val      (alu_val[i])
    );
    hzu_branch_path #(.XLEN(XLEN)) u_br (
      .fwd_mode  (fwd_mode),
      .ex_hit    (ex_br_hit[i]),
      .mem_hit   (mem_br_hit[i]),
      .mem_load  (mem_load),
      .kill      (stall),
      .rf_val    (rf[i]),
      .mem_val   (mem_wr_val),
      .stall_req (br_stall[i]),
      .bstall_req(br_bstall[i]),
      .fwd       (br_fwd[i]),
      .val       (br_val[i])
    );
  end

  assign stall         = (|alu_stall) || (|br_stall);
  assign branch_stall  = |br_bstall;
  assign hold_front    = stall;
  assign insert_bubble = stall;

  assign fwd_sel_rs = sel[0];
  assign fwd_sel_rt = sel[1];
  assign alu_rs_val = alu_val[0];
  assign alu_rt_val = alu_val[1];
  assign br_fwd_rs  = br_fwd[0];
  assign br_fwd_rt  = br_fwd[1];
  assign br_rs_val  = br_val[0];
  assign br_rt_val  = br_val[1];

  always_comb begin
    if (stall)
      status = HS_STALL;
    else if ((sel[0] != FWD_NONE) || (sel[1] != FWD_NONE) || (|br_fwd))
      status = HS_FWD;
    else
      status = HS_IDLE;
  end
  assign hz_status = status;
endmodule

// File: rtl/hzu_checker.sv
module hzu_checker #(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input logic            fwd_mode,
  input logic [AW-1:0]   dec_rs_num,
  input logic            dec_rs_alu,
  input logic            dec_rs_br,
  input logic            dec_rt_br,
  input logic [XLEN-1:0] dec_rs_val,
  input logic [AW-1:0]   ex_dest,
  input logic            ex_wen,
  input logic            ex_load,
  input logic [XLEN-1:0] ex_alu_val,
  input logic [AW-1:0]   mem_dest,
  input logic [XLEN-1:0] mem_wr_val,
  input logic            stall,
  input logic            branch_stall,
  input logic            hold_front,
  input logic            insert_bubble,
  input logic [1:0]      fwd_sel_rs,
  input logic [1:0]      fwd_sel_rt,
  input logic [XLEN-1:0] alu_rs_val,
  input logic            br_fwd_rs,
  input logic            br_fwd_rt,
  input logic [XLEN-1:0] br_rs_val,
  input logic [1:0]      hz_status
);
  always_comb begin
    if (ex_dest == '0 && mem_dest == '0)
      AST_ZERO_DEST_QUIET: assert (!stall && fwd_sel_rs == 2'b00 && fwd_sel_rt == 2'b00 && !br_fwd_rs && !br_fwd_rt) else $error("zero destination acted"); // R1
    if (fwd_sel_rs == 2'b10)
      AST_MEM_FWD_VALUE: assert (alu_rs_val == mem_wr_val) else $error("rs memory forward value"); // R2
    if (fwd_sel_rs == 2'b01)
      AST_EX_FWD_VALUE: assert (alu_rs_val == ex_alu_val) else $error("rs execute forward value"); // R3
    if (fwd_mode && dec_rs_alu && ex_wen && ex_load && ex_dest != '0 && ex_dest == dec_rs_num)
      AST_EX_LOAD_STALL: assert (stall) else $error("execute load did not stall"); // R4
    if (!fwd_mode)
      AST_STALL_ONLY_NOFWD: assert (fwd_sel_rs == 2'b00 && fwd_sel_rt == 2'b00 && !br_fwd_rs && !br_fwd_rt) else $error("forward in stall-only mode"); // R6
    if (branch_stall)
      AST_BSTALL_IMPLIES_STALL: assert (stall && (dec_rs_br || dec_rt_br)) else $error("branch stall alone"); // R7
    if (br_fwd_rs)
      AST_BR_FWD_VALUE: assert (br_rs_val == mem_wr_val && !stall) else $error("rs branch forward value"); // R8
    if (stall)
      AST_STALL_QUIET: assert (hold_front && insert_bubble && fwd_sel_rs == 2'b00 && fwd_sel_rt == 2'b00 && !br_fwd_rs && !br_fwd_rt && hz_status == 2'b10) else $error("stall not clean"); // R10
    if (!stall)
      AST_NO_HOLD_IDLE: assert (!hold_front && !insert_bubble) else $error("hold without stall"); // R10
    if (fwd_sel_rs == 2'b00)
      AST_RF_PASS: assert (alu_rs_val == dec_rs_val) else $error("rs pass-through"); // R11
  end
endmodule

bind hazard_fwd_unit hzu_checker #(.XLEN(XLEN), .AW(AW)) u_hzu_checker (
  .fwd_mode     (fwd_mode),
  .dec_rs_num   (dec_rs_num),
  .dec_rs_alu   (dec_rs_alu),
  .dec_rs_br    (dec_rs_br),
  .dec_rt_br    (dec_rt_br),
  .dec_rs_val   (dec_rs_val),
  .ex_dest      (ex_dest),
  .ex_wen       (ex_wen),
  .ex_load      (ex_load),
  .ex_alu_val   (ex_alu_val),
  .mem_dest     (mem_dest),
  .mem_wr_val   (mem_wr_val),
  .stall        (stall),
  .branch_stall (branch_stall),
  .hold_front   (hold_front),
  .insert_bubble(insert_bubble),
  .fwd_sel_rs   (fwd_sel_rs),
  .fwd_sel_rt   (fwd_sel_rt),
  .alu_rs_val   (alu_rs_val),
  .br_fwd_rs    (br_fwd_rs),
  .br_fwd_rt    (br_fwd_rt),
  .br_rs_val    (br_rs_val),
  .hz_status    (hz_status)
);

// File: tb/hazard_fwd_unit_test.sv
`timescale 1ns/1ps
module hazard_fwd_unit_test;
  localparam int XLEN = 32;
  localparam int AW   = 5;
  localparam int WD_CYCLES = 5000;
  localparam logic [XLEN-1:0] RSV = 32'h1111_0001;
  localparam logic [XLEN-1:0] RTV = 32'h2222_0002;
  localparam logic [XLEN-1:0] EXV = 32'hAAAA_000A;
  localparam logic [XLEN-1:0] MMV = 32'hBBBB_000B;

  typedef struct packed {
    logic       mode;
    logic [4:0] rs, rt;
    logic       ra, ta, rb, tb;
    logic [4:0] ed;
    logic       ew, el;
    logic [4:0] md;
    logic       mw, ml;
    logic       st, bs;
    logic [1:0] frs, frt;
    logic       brs, brt;
    logic [1:0] sts;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    // mode rs rt ra ta rb tb | ed ew el | md mw ml || st bs frs frt brs brt sts req
    '{1'b1,5'd2,5'd3,1'b1,1'b1,1'b0,1'b0, 5'd5,1'b1,1'b0, 5'd6,1'b1,1'b0, 1'b0,1'b0,2'd0,2'd0,1'b0,1'b0,2'd0, 8'd11}, // R11 idle
    '{1'b1,5'd0,5'd3,1'b1,1'b1,1'b1,1'b0, 5'd0,1'b1,1'b0, 5'd0,1'b1,1'b0, 1'b0,1'b0,2'd0,2'd0,1'b0,1'b0,2'd0, 8'd1},  // R1 dest 0
    '{1'b1,5'd2,5'd3,1'b1,1'b1,1'b1,1'b1, 5'd2,1'b0,1'b0, 5'd3,1'b0,1'b0, 1'b0,1'b0,2'd0,2'd0,1'b0,1'b0,2'd0, 8'd1},  // R1 wen 0
    '{1'b1,5'd2,5'd3,1'b1,1'b1,1'b0,1'b0, 5'd5,1'b1,1'b0, 5'd2,1'b1,1'b0, 1'b0,1'b0,2'd2,2'd0,1'b0,1'b0,2'd1, 8'd2},  // R2 rs
    '{1'b1,5'd2,5'd3,1'b1,1'b1,1'b0,1'b0, 5'd5,1'b1,1'b0, 5'd3,1'b1,1'b1, 1'b0,1'b0,2'd0,2'd2,1'b0,1'b0,2'd1, 8'd2},  // R2 rt, load
    '{1'b1,5'd2,5'd3,1'b1,1'b1,1'b0,1'b0, 5'd2,1'b1,1'b0, 5'd6,1'b1,1'b0, 1'b0,1'b0,2'd1,2'd0,1'b0,1'b0,2'd1, 8'd3},  // R3 rs
    '{1'b1,5'd4,5'd4,1'b1,1'b1,1'b0,1'b0, 5'd4,1'b1,1'b0, 5'd6,1'b1,1'b0, 1'b0,1'b0,2'd1,2'd1,1'b0,1'b0,2'd1, 8'd3},  // R3 both
    '{1'b1,5'd2,5'd3,1'b1,1'b1,1'b0,1'b0, 5'd2,1'b1,1'b0, 5'd2,1'b1,1'b0, 1'b0,1'b0,2'd1,2'd0,1'b0,1'b0,2'd1, 8'd5},  // R5 same op
    '{1'b1,5'd2,5'd3,1'b1,1'b1,1'b0,1'b0, 5'd3,1'b1,1'b0, 5'd2,1'b1,1'b0, 1'b0,1'b0,2'd2,2'd1,1'b0,1'b0,2'd1, 8'd5},  // R5 split
    '{1'b1,5'd2,5'd3,1'b1,1'b1,1'b0,1'b0, 5'd2,1'b1,1'b1, 5'd6,1'b1,1'b0, 1'b1,1'b0,2'd0,2'd0,1'b0,1'b0,2'd2, 8'd4},  // R4 rs
    '{1'b1,5'd2,5'd3,1'b0,1'b1,1'b0,1'b0, 5'd3,1'b1,1'b1, 5'd2,1'b1,1'b0, 1'b1,1'b0,2'd0,2'd0,1'b0,1'b0,2'd2, 8'd4},  // R4 rt
    '{1'b1,5'd2,5'd3,1'b0,1'b0,1'b0,1'b0, 5'd2,1'b1,1'b1, 5'd3,1'b1,1'b0, 1'b0,1'b0,2'd0,2'd0,1'b0,1'b0,2'd0, 8'd9},  // R9
    '{1'b0,5'd2,5'd3,1'b1,1'b1,1'b0,1'b0, 5'd5,1'b1,1'b0, 5'd2,1'b1,1'b0, 1'b1,1'b0,2'd0,2'd0,1'b0,1'b0,2'd2, 8'd6},  // R6 mem
    '{1'b0,5'd2,5'd3,1'b1,1'b1,1'b0,1'b0, 5'd3,1'b1,1'b0, 5'd6,1'b1,1'b0, 1'b1,1'b0,2'd0,2'd0,1'b0,1'b0,2'd2, 8'd6},  // R6 ex
    '{1'b1,5'd2,5'd3,1'b0,1'b0,1'b1,1'b0, 5'd2,1'b1,1'b0, 5'd6,1'b1,1'b0, 1'b1,1'b1,2'd0,2'd0,1'b0,1'b0,2'd2, 8'd7},  // R7 fwd mode
    '{1'b0,5'd2,5'd3,1'b0,1'b0,1'b0,1'b1, 5'd3,1'b1,1'b1, 5'd6,1'b1,1'b0, 1'b1,1'b1,2'd0,2'd0,1'b0,1'b0,2'd2, 8'd7},  // R7 stall-only
    '{1'b1,5'd2,5'd3,1'b0,1'b0,1'b1,1'b0, 5'd5,1'b1,1'b0, 5'd2,1'b1,1'b0, 1'b0,1'b0,2'd0,2'd0,1'b1,1'b0,2'd1, 8'd8},  // R8 rs fwd
    '{1'b1,5'd2,5'd3,1'b0,1'b0,1'b0,1'b1, 5'd5,1'b1,1'b0, 5'd3,1'b1,1'b0, 1'b0,1'b0,2'd0,2'd0,1'b0,1'b1,2'd1, 8'd8},  // R8 rt fwd
    '{1'b1,5'd2,5'd3,1'b0,1'b0,1'b1,1'b0, 5'd5,1'b1,1'b0, 5'd2,1'b1,1'b1, 1'b1,1'b0,2'd0,2'd0,1'b0,1'b0,2'd2, 8'd8},  // R8 load
    '{1'b0,5'd2,5'd3,1'b0,1'b0,1'b1,1'b0, 5'd5,1'b1,1'b0, 5'd2,1'b1,1'b0, 1'b1,1'b0,2'd0,2'd0,1'b0,1'b0,2'd2, 8'd8},  // R8 stall-only
    '{1'b1,5'd2,5'd3,1'b1,1'b0,1'b1,1'b0, 5'd2,1'b1,1'b0, 5'd2,1'b1,1'b0, 1'b1,1'b1,2'd0,2'd0,1'b0,1'b0,2'd2, 8'd10}, // R10 branch
    '{1'b1,5'd2,5'd3,1'b0,1'b0,1'b0,1'b0, 5'd5,1'b1,1'b0, 5'd2,1'b1,1'b0, 1'b0,1'b0,2'd0,2'd0,1'b0,1'b0,2'd0, 8'd9},  // R9
    '{1'b1,5'd2,5'd3,1'b1,1'b1,1'b0,1'b0, 5'd2,1'b1,1'b1, 5'd3,1'b1,1'b0, 1'b1,1'b0,2'd0,2'd0,1'b0,1'b0,2'd2, 8'd10}  // R10 alu
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic            fwd_mode;
  logic [AW-1:0]   dec_rs_num, dec_rt_num, ex_dest, mem_dest;
  logic            dec_rs_alu, dec_rt_alu, dec_rs_br, dec_rt_br;
  logic [XLEN-1:0] dec_rs_val, dec_rt_val, ex_alu_val, mem_wr_val;
  logic            ex_wen, ex_load, mem_wen, mem_load;
  logic            stall, branch_stall, hold_front, insert_bubble;
  logic [1:0]      fwd_sel_rs, fwd_sel_rt, hz_status;
  logic [XLEN-1:0] alu_rs_val, alu_rt_val, br_rs_val, br_rt_val;
  logic            br_fwd_rs, br_fwd_rt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  hazard_fwd_unit #(.XLEN(XLEN), .AW(AW)) uut (
    .fwd_mode(fwd_mode), .dec_rs_num(dec_rs_num), .dec_rt_num(dec_rt_num),
    .dec_rs_alu(dec_rs_alu), .dec_rt_alu(dec_rt_alu), .dec_rs_br(dec_rs_br),
    .dec_rt_br(dec_rt_br), .dec_rs_val(dec_rs_val), .dec_rt_val(dec_rt_val),
    .ex_dest(ex_dest), .ex_wen(ex_wen), .ex_load(ex_load), .ex_alu_val(ex_alu_val),
    .mem_dest(mem_dest), .mem_wen(mem_wen), .mem_load(mem_load), .mem_wr_val(mem_wr_val),
    .stall(stall), .branch_stall(branch_stall), .hold_front(hold_front),
    .insert_bubble(insert_bubble), .fwd_sel_rs(fwd_sel_rs), .fwd_sel_rt(fwd_sel_rt),
    .alu_rs_val(alu_rs_val), .alu_rt_val(alu_rt_val), .br_fwd_rs(br_fwd_rs),
    .br_fwd_rt(br_fwd_rt), .br_rs_val(br_rs_val), .br_rt_val(br_rt_val),
    .hz_status(hz_status)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what, input int req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] pick(input logic [1:0] s, input logic [XLEN-1:0] rfv);
    return (s == 2'd1) ? EXV : (s == 2'd2) ? MMV : rfv;
  endfunction

  task automatic apply(input vec_t v);
    @(negedge clk);
    fwd_mode = v.mode; dec_rs_num = v.rs; dec_rt_num = v.rt;
    dec_rs_alu = v.ra; dec_rt_alu = v.ta; dec_rs_br = v.rb; dec_rt_br = v.tb;
    ex_dest = v.ed; ex_wen = v.ew; ex_load = v.el;
    mem_dest = v.md; mem_wen = v.mw; mem_load = v.ml;
    dec_rs_val = RSV; dec_rt_val = RTV; ex_alu_val = EXV; mem_wr_val = MMV;
    #5;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(WD_CYCLES * 20);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    fwd_mode = 1'b1; dec_rs_num = '0; dec_rt_num = '0;
    dec_rs_alu = 1'b0; dec_rt_alu = 1'b0; dec_rs_br = 1'b0; dec_rt_br = 1'b0;
    dec_rs_val = RSV; dec_rt_val = RTV; ex_dest = '0; ex_wen = 1'b0; ex_load = 1'b0;
    ex_alu_val = EXV; mem_dest = '0; mem_wen = 1'b0; mem_load = 1'b0; mem_wr_val = MMV;
    repeat (3) @(posedge clk);
    #5;
    // reset state with quiet inputs: R11 idle, R10 no hold
    chk({31'd0, stall}, 32'd0, "reset stall", 11);
    chk({30'd0, hz_status}, 32'd0, "reset status", 11);
    chk({31'd0, hold_front}, 32'd0, "reset hold", 10);
    chk(alu_rs_val, RSV, "reset rs pass", 11);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      apply(v);
      chk({31'd0, stall}, {31'd0, v.st}, $sformatf("v%0d stall", i), int'(v.req));
      chk({31'd0, branch_stall}, {31'd0, v.bs}, $sformatf("v%0d branch_stall", i), int'(v.req));
      chk({30'd0, fwd_sel_rs}, {30'd0, v.frs}, $sformatf("v%0d sel_rs", i), int'(v.req));
      chk({30'd0, fwd_sel_rt}, {30'd0, v.frt}, $sformatf("v%0d sel_rt", i), int'(v.req));
      chk({30'd0, br_fwd_rt, br_fwd_rs}, {30'd0, v.brt, v.brs}, $sformatf("v%0d br_fwd", i), int'(v.req));
      chk({30'd0, hz_status}, {30'd0, v.sts}, $sformatf("v%0d status", i), int'(v.req));
      chk({30'd0, hold_front, insert_bubble}, {30'd0, v.st, v.st}, $sformatf("v%0d hold/bubble", i), 10);
      chk(alu_rs_val, pick(v.frs, RSV), $sformatf("v%0d alu_rs_val", i), int'(v.req));
      chk(alu_rt_val, pick(v.frt, RTV), $sformatf("v%0d alu_rt_val", i), int'(v.req));
      chk(br_rs_val, v.brs ? MMV : RSV, $sformatf("v%0d br_rs_val", i), int'(v.req));
      chk(br_rt_val, v.brt ? MMV : RTV, $sformatf("v%0d br_rt_val", i), int'(v.req));
    end

    // R2: forwarded value follows the memory-stage write value
    apply(VECS[3]);
    mem_wr_val = 32'h5A5A_1234; #2;
    chk(alu_rs_val, 32'h5A5A_1234, "R2 value tracks mem_wr_val", 2);
    // R8: branch forward value follows too
    apply(VECS[16]);
    mem_wr_val = 32'h0F0F_4321; #2;
    chk(br_rs_val, 32'h0F0F_4321, "R8 branch value tracks mem_wr_val", 8);
    // R3: execute result follows
    apply(VECS[5]);
    ex_alu_val = 32'hC0DE_0042; #2;
    chk(alu_rs_val, 32'hC0DE_0042, "R3 value tracks ex_alu_val", 3);
    // R1: register 0 in both stages with every flag set never stalls
    @(negedge clk);
    fwd_mode = 1'b0; dec_rs_num = '0; dec_rt_num = '0;
    dec_rs_alu = 1'b1; dec_rt_alu = 1'b1; dec_rs_br = 1'b1; dec_rt_br = 1'b1;
    ex_dest = '0; ex_wen = 1'b1; ex_load = 1'b1; mem_dest = '0; mem_wen = 1'b1; mem_load = 1'b1;
    #5;
    chk({31'd0, stall}, 32'd0, "R1 register 0 stall-only", 1);
    chk({31'd0, branch_stall}, 32'd0, "R1 register 0 branch", 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule